// File: doc/BRIEF.md
# Signed Energy Accumulator Bank with Half-Scale Interrupt

This block is the second integration stage of a multi-phase energy meter. For each phase there is one channel for total power and one for fundamental power. On each of these channels a first stage delivers single-cycle pulse strobes, each with a direction bit. Every pulse adds or removes one LSB from that channel's signed energy register. The registers wrap silently at full scale in either direction.

A change of the bit just below the sign bit in any register raises a status flag. Total-power channels share one flag and fundamental-power channels share the other. An active-low interrupt output is asserted while any flag is set and its enable bit is on. The host reads registers through a combinational read port. When a control bit is set, the selected energy register is cleared after it is read. Status flags are cleared by writing ones.

Top module: `energy_bank`

## Requirements
- R1: A pulse on channel k with its sign bit 0 adds one to register k, and with its sign bit 1 subtracts one. A register without a pulse holds its value.
- R2: Counting up from the largest positive value gives the most negative value. Counting down from the most negative value gives the largest positive value. Counting continues past the wrap with no saturation.
- R3: Status bit 0 is set on the edge where bit DATA_W-2 of any total channel (channels 0 to NUM_PH-1) changes due to a pulse. Status bit 1 does the same for the fundamental channels (channels NUM_PH to 2*NUM_PH-1).
- R4: A write with wr_sel_i=0 clears each status bit whose data bit is 1. Status bits whose data bit is 0 keep their value.
- R5: If a new event for a status bit occurs in the same cycle as a write-one-to-clear of that bit, the bit remains set.
- R6: A write with wr_sel_i=1 loads the enable bits from wr_data_i[1:0]. irq_no is low exactly when some status bit and its enable bit are both 1.
- R7: rd_data_o combinationally returns the register picked by rd_sel_i. Values 0 to 2 select the total channels, 3 to 5 the fundamental channels, and 6 the status. Value 7 returns the enable bits in [1:0] and the clear-on-read bit in [6].
- R8: A write with wr_sel_i=2 loads the clear-on-read bit from wr_data_i[6]. While it is 1, an energy register selected with rd_en_i high is zero after that clock edge. While it is 0, reads change nothing.
- R9: If a pulse arrives on the channel being cleared by a read, the register takes +1 or -1 (per its sign bit) instead of zero.
- R10: After reset all energy registers, status, enables and the clear-on-read bit are zero, and irq_no is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pulse_i | input | 2*NUM_PH | Per-channel energy pulse strobe |
| sign_i | input | 2*NUM_PH | Per-channel direction, 1 = decrement |
| rd_en_i | input | 1 | Read access strobe (triggers clear-on-read) |
| rd_sel_i | input | 3 | Read register select |
| rd_data_o | output | DATA_W | Read data |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 2 | Write select: 0 status, 1 enables, 2 control |
| wr_data_i | input | DATA_W | Write data |
| status_o | output | 2 | Half-scale flags: [0] total, [1] fundamental |
| irq_no | output | 1 | Active-low interrupt |

## Verification
A register that miscounts or wraps wrongly shows up at the read port right after the pulse edge. It also shows up one pulse late or early at status_o, because the flag depends on the exact value where the upper bit flips. Lost or spurious status bits appear on irq_no in the same cycle once the matching enable is set. The bench scales the word to 8 bits, so that both flag crossings and both wraps are reached within a few hundred pulses.

// File: rtl/energy_pkg.sv
package energy_pkg;
  localparam int unsigned RD_SEL_W   = 3;
  localparam int unsigned WR_SEL_W   = 2;
  localparam int unsigned N_FLAG     = 2;
  localparam int unsigned CLR_BIT    = 6;

  typedef enum logic [WR_SEL_W-1:0] {
    WR_STATUS = 2'd0,
    WR_ENABLE = 2'd1,
    WR_CTRL   = 2'd2
  } wr_sel_e;

  localparam logic [RD_SEL_W-1:0] RD_STATUS = 3'd6;
  localparam logic [RD_SEL_W-1:0] RD_CFG    = 3'd7;
endpackage

// File: rtl/energy_acc.sv
module energy_acc #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pulse_i,
  input  logic              dn_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] val_o,
  output logic              half_o
);
  localparam int unsigned HB = DATA_W - 2;

  logic [DATA_W-1:0] val_q, step;

  assign step = dn_i ? val_q - 1'b1 : val_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       val_q <= '0;
    else if (clr_i)    val_q <= pulse_i ? (dn_i ? '1 : DATA_W'(1)) : '0;
    else if (pulse_i)  val_q <= step;
  end

  // flag is taken from the counting step only, never from a clear
  assign half_o = pulse_i && !clr_i && (step[HB] != val_q[HB]);
  assign val_o  = val_q;

  a_r1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pulse_i && !clr_i |=> $stable(val_q));
  a_r2_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_i && !clr_i |=> val_q != $past(val_q));
  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !pulse_i |=> val_q == '0);
  a_r9_seed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && pulse_i |=> $countones(val_q) == 1 || val_q == '1);
endmodule

// File: rtl/energy_flags.sv
module energy_flags #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] ev_i,
  input  logic [N-1:0] w1c_i,
  input  logic         en_we_i,
  input  logic [N-1:0] en_d_i,
  output logic [N-1:0] status_o,
  output logic [N-1:0] en_o,
  output logic         irq_no
);
  logic [N-1:0] st_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
      en_q <= '0;
    end else begin
      st_q <= (st_q & ~w1c_i) | ev_i;  // event wins over clear
      if (en_we_i) en_q <= en_d_i;
    end
  end

  assign status_o = st_q;
  assign en_o     = en_q;
  assign irq_no   = ~|(st_q & en_q);

  for (genvar i = 0; i < N; i++) begin : g_chk
    a_r5_event_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev_i[i] |=> st_q[i]);
    a_r4_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
      w1c_i[i] && !ev_i[i] |=> !st_q[i]);
    a_r3_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !w1c_i[i] && !ev_i[i] |=> $stable(st_q[i]));
  end
endmodule

// File: rtl/energy_bank.sv
module energy_bank
  import energy_pkg::*;
#(
  parameter int unsigned NUM_PH = 3,
  parameter int unsigned DATA_W = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [2*NUM_PH-1:0]   pulse_i,
  input  logic [2*NUM_PH-1:0]   sign_i,
  input  logic                  rd_en_i,
  input  logic [RD_SEL_W-1:0]   rd_sel_i,
  output logic [DATA_W-1:0]     rd_data_o,
  input  logic                  wr_en_i,
  input  logic [WR_SEL_W-1:0]   wr_sel_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  output logic [N_FLAG-1:0]     status_o,
  output logic                  irq_no
);
  localparam int unsigned NCH = 2 * NUM_PH;

  logic [DATA_W-1:0] val   [NCH];
  logic [NCH-1:0]    half, clr;
  logic [N_FLAG-1:0] ev, w1c, en;
  logic              rst_rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_rd_q <= 1'b0;
    else if (wr_en_i && wr_sel_i == WR_CTRL) rst_rd_q <= wr_data_i[CLR_BIT];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign clr[c] = rd_en_i && rst_rd_q && (rd_sel_i == RD_SEL_W'(c));
    energy_acc #(.DATA_W(DATA_W)) i_acc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pulse_i(pulse_i[c]),
      .dn_i   (sign_i[c]),
      .clr_i  (clr[c]),
      .val_o  (val[c]),
      .half_o (half[c])
    );
  end

  assign ev[0] = |half[NUM_PH-1:0];
  assign ev[1] = |half[NCH-1:NUM_PH];
  assign w1c   = (wr_en_i && wr_sel_i == WR_STATUS) ? wr_data_i[N_FLAG-1:0] : '0;

  energy_flags #(.N(N_FLAG)) i_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ev_i    (ev),
    .w1c_i   (w1c),
    .en_we_i (wr_en_i && wr_sel_i == WR_ENABLE),
    .en_d_i  (wr_data_i[N_FLAG-1:0]),
    .status_o(status_o),
    .en_o    (en),
    .irq_no  (irq_no)
  );

  always_comb begin
    rd_data_o = '0;
    if (rd_sel_i == RD_STATUS) begin
      rd_data_o[N_FLAG-1:0] = status_o;
    end else if (rd_sel_i == RD_CFG) begin
      rd_data_o[N_FLAG-1:0] = en;
      rd_data_o[CLR_BIT]    = rst_rd_q;
    end else begin
      for (int c = 0; c < NCH; c++)
        if (rd_sel_i == RD_SEL_W'(c)) rd_data_o = val[c];
    end
  end

  a_r6_irq_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_no |-> |status_o);
  a_r8_no_clr_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_rd_q |-> clr == '0);
  a_r3_flag_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[0]) |-> $past(|half[NUM_PH-1:0]));
endmodule

// File: tb/test_energy_bank.sv
module test_energy_bank;
  localparam int CLK_P = 10;
  localparam int NPH   = 3;
  localparam int W     = 8;
  localparam int NROW  = 11;

  logic           clk = 0, rst_n = 0;
  logic [5:0]     pulse = '0, sign = '0;
  logic           rd_en = 0, wr_en = 0;
  logic [2:0]     rd_sel = '0;
  logic [1:0]     wr_sel = '0;
  logic [W-1:0]   wr_data = '0, rd_data;
  logic [1:0]     status;
  logic           irq_n;
  int             total = 0, bad = 0;
  logic [W-1:0]   v;

  always #(CLK_P/2) clk = ~clk;

  energy_bank #(.NUM_PH(NPH), .DATA_W(W)) i_energy_bank (
    .clk_i(clk), .rst_ni(rst_n), .pulse_i(pulse), .sign_i(sign),
    .rd_en_i(rd_en), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .status_o(status), .irq_no(irq_n));

  // {ch[2:0], down, count[7:0], expected value[7:0], expected status[1:0]}
  localparam logic [21:0] VEC [NROW] = '{
    {3'd0, 1'b0, 8'd63,  8'h3F, 2'b00},
    {3'd0, 1'b0, 8'd1,   8'h40, 2'b01},
    {3'd1, 1'b0, 8'd1,   8'h01, 2'b00},
    {3'd1, 1'b1, 8'd1,   8'h00, 2'b00},
    {3'd3, 1'b1, 8'd1,   8'hFF, 2'b10},
    {3'd3, 1'b1, 8'd63,  8'hC0, 2'b00},
    {3'd3, 1'b1, 8'd1,   8'hBF, 2'b10},
    {3'd2, 1'b0, 8'd127, 8'h7F, 2'b01},
    {3'd2, 1'b0, 8'd1,   8'h80, 2'b01},
    {3'd5, 1'b1, 8'd129, 8'h7F, 2'b10},
    {3'd4, 1'b0, 8'd64,  8'h40, 2'b10}
  };

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] s, output logic [W-1:0] d);
    rd_sel = s;
    #1 d = rd_data;
  endtask

  task automatic wr(input logic [1:0] s, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_data = '0;
  endtask

  task automatic pulses(input int ch, input logic dn, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pulse = '0; sign = '0;
      pulse[ch] = 1'b1; sign[ch] = dn;
    end
    @(negedge clk);
    pulse = '0; sign = '0;
  endtask

  initial begin
    #(CLK_P * 100000);
    bad++; total++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 3) rst_n = 1;
    @(negedge clk);
    // R10 reset state
    for (int c = 0; c < 8; c++) begin
      rd(3'(c), v);
      chk("R10 reset reg", v, '0);
    end
    chk("R10 irq idle", {7'd0, irq_n}, 8'd1);

    // R1 R2 R3: table walk
    for (int r = 0; r < NROW; r++) begin
      wr(2'd0, 8'h03);
      pulses(int'(VEC[r][21:19]), VEC[r][18], int'(VEC[r][17:10]));
      rd(VEC[r][21:19], v);
      chk($sformatf("R1/R2 row %0d value", r), v, VEC[r][9:2]);
      chk($sformatf("R3 row %0d status", r), {6'd0, status}, {6'd0, VEC[r][1:0]});
    end

    // R4 clear both
    wr(2'd0, 8'h03);
    chk("R4 w1c clears", {6'd0, status}, 8'd0);

    // R5 event with simultaneous clear: ch0 0x40 -> 0x3F
    @(negedge clk);
    pulse[0] = 1; sign[0] = 1; wr_en = 1; wr_sel = 2'd0; wr_data = 8'h01;
    @(negedge clk);
    pulse = '0; sign = '0; wr_en = 0; wr_data = '0;
    chk("R5 event wins", {6'd0, status}, 8'd1);
    rd(3'd0, v);
    chk("R1 ch0 down", v, 8'h3F);

    // R4 writing zeros keeps the bit
    wr(2'd0, 8'h02);
    chk("R4 zero bit kept", {6'd0, status}, 8'd1);

    // R6 masking
    chk("R6 masked irq high", {7'd0, irq_n}, 8'd1);
    wr(2'd1, 8'h01);
    chk("R6 enabled irq low", {7'd0, irq_n}, 8'd0);
    wr(2'd1, 8'h02);
    chk("R6 other enable irq high", {7'd0, irq_n}, 8'd1);
    wr(2'd1, 8'h01);
    wr(2'd0, 8'h01);
    chk("R6 irq released", {7'd0, irq_n}, 8'd1);
    rd(3'd7, v);
    chk("R7 cfg readback", v, 8'h01);

    // R8 read without clear mode does not clear
    @(negedge clk);
    rd_en = 1; rd(3'd2, v);
    @(negedge clk);
    rd_en = 0;
    rd(3'd2, v);
    chk("R8 no clear when off", v, 8'h80);

    // R8 clear on read
    wr(2'd2, 8'h40);
    rd(3'd7, v);
    chk("R7 cfg clr bit", v, 8'h41);
    @(negedge clk);
    rd_en = 1; rd(3'd2, v);
    chk("R8 read returns value", v, 8'h80);
    @(negedge clk);
    rd_en = 0;
    rd(3'd2, v);
    chk("R8 cleared after read", v, 8'h00);

    // R9 pulse during clearing read
    @(negedge clk);
    rd_en = 1; pulse[4] = 1; sign[4] = 0; rd(3'd4, v);
    chk("R9 read old", v, 8'h40);
    @(negedge clk);
    rd_en = 0; pulse = '0; sign = '0;
    rd(3'd4, v);
    chk("R9 seeded +1", v, 8'h01);
    @(negedge clk);
    rd_en = 1; pulse[5] = 1; sign[5] = 1; rd(3'd5, v);
    @(negedge clk);
    rd_en = 0; pulse = '0; sign = '0;
    rd(3'd5, v);
    chk("R9 seeded -1", v, 8'hFF);
    rd(3'd3, v);
    chk("R8 other ch untouched", v, 8'hBF);

    // R10 reset mid-run
    @(negedge clk);
    rst_n = 0;
    #1 rd(3'd3, v);
    chk("R10 reset clears reg", v, 8'h00);
    rd(3'd7, v);
    chk("R10 reset clears cfg", v, 8'h00);
    rst_n = 1;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule